// File: doc/BRIEF.md
# Per-Pixel Colour Source Selector

This block sits in a display output path that keeps two picture planes side by side. For every pixel it receives three words that advance together: an 8-bit colour index, a 32-bit true-colour word and a 32-bit control word. The control word decides, pixel by pixel, whether the pixel shows its own 24-bit colour or the colour that a 256-entry lookup table holds for its index. Both kinds of pixel can therefore be mixed freely inside one frame.

The lookup table lives outside the block and is read through a synchronous port: the block presents an address with a read strobe, and the entry comes back one clock later. The block delays the direct colour by the same amount, so both sources meet at one output register. Pixels are taken in with a valid/ready handshake and leave as packed 24-bit RGB with a valid flag, in arrival order, two cycles after acceptance when the output is not held. A marker flags the last pixel of every fixed-length scan line.

Top module: `pix_color_select`

## Requirements
- R1: After a synchronous reset `out_valid` and `out_eol` are 0 and `in_ready` is 1.
- R2: The 32-bit words arrive in memory byte order, first byte in bits 7:0. A pixel takes the direct path only when bits 7:0 of `in_ctrl` are 0x03. Its output is then red = `in_truecolor[15:8]`, green = `in_truecolor[23:16]`, blue = `in_truecolor[31:24]`, and bits 7:0 of `in_truecolor` are ignored.
- R3: For any other value in bits 7:0 of `in_ctrl` the output is the table entry at `in_index`. A value of 0x03 in any other byte of `in_ctrl` does not select the direct path.
- R4: In the cycle a pixel is accepted, `pal_rd_en` is 1 and `pal_addr` equals `in_index`.
- R5: Without backpressure, a pixel accepted at clock edge N appears on `out_valid` after edge N+2. Outputs keep the order of acceptance.
- R6: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_valid`, `out_rgb` and `out_eol` hold their values.
- R7: A table-path pixel held inside the block by backpressure still leaves with the entry for its own index, because the block keeps re-reading that address until the pixel moves on.
- R8: `out_eol` is 1 exactly on every 1024th pixel accepted since reset (line length 1024).
- R9: A pixel is taken only when `in_valid` and `in_ready` are both 1. Cycles with `in_valid` at 0 produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take a pixel this cycle |
| in_index | input | 8 | Colour index of the pixel |
| in_truecolor | input | 32 | True-colour word, memory byte order |
| in_ctrl | input | 32 | Control word, memory byte order |
| pal_rd_en | output | 1 | Table read strobe |
| pal_addr | output | 8 | Table read address |
| pal_data | input | 24 | Table entry, one cycle after the strobe |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_rgb | output | 24 | Pixel colour, red 23:16, green 15:8, blue 7:0 |
| out_eol | output | 1 | Output pixel is last of its scan line |

## Verification
The delicate case is a downstream stall that arrives in the same cycle as the table's answer for a waiting table-path pixel, while a new pixel is also being offered at the input. The bench provokes this by dropping `out_ready` at random during long streams that mix both paths and cross line ends. A scoreboard fed at acceptance checks each colour, the line marker and the order. It also checks that `in_ready` falls and the output holds during each stall.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

    localparam int IDX_W     = 8;
    localparam int WORD_W    = 32;
    localparam int CH_W      = 8;
    localparam int RGB_W     = 3 * CH_W;
    localparam int LINE_PIX  = 1024;
    localparam logic [CH_W-1:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [CH_W-1:0] red;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] blue;
    } rgb_t;

    typedef enum logic {
        SRC_TABLE  = 1'b0,
        SRC_DIRECT = 1'b1
    } src_e;

    typedef struct packed {
        src_e             src;
        logic [IDX_W-1:0] idx;
        rgb_t             direct;
        logic             eol;
    } pix_t;

    // memory byte order -> numeric order
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/pxsel_decode.sv
module pxsel_decode
    import pxsel_pkg::*;
#(
    parameter bit LANE_SWAP = 1'b1
) (
    input  logic [WORD_W-1:0] truecolor,
    input  logic [WORD_W-1:0] ctrl,
    output src_e              src,
    output rgb_t              direct
);

    logic [WORD_W-1:0] tc_num;
    logic [WORD_W-1:0] ctrl_num;

    generate
        if (LANE_SWAP) begin : g_swap
            assign tc_num   = swap_bytes(truecolor);
            assign ctrl_num = swap_bytes(ctrl);
        end else begin : g_native
            assign tc_num   = truecolor;
            assign ctrl_num = ctrl;
        end
    endgenerate

    always_comb begin
        src = (ctrl_num[WORD_W-1 -: CH_W] == DIRECT_TAG) ? SRC_DIRECT : SRC_TABLE;
        direct.red   = tc_num[3*CH_W-1 -: CH_W];
        direct.green = tc_num[2*CH_W-1 -: CH_W];
        direct.blue  = tc_num[CH_W-1:0];
    end

endmodule

// File: rtl/pxsel_linepos.sv
module pxsel_linepos #(
    parameter int LINE_LEN = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic last
);

    localparam int CNT_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(LINE_LEN - 1);

    logic [CNT_W-1:0] pos;

    assign last = (pos == LAST_POS);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (step) begin
            pos <= last ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/pxsel_pipe.sv
module pxsel_pipe
    import pxsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_fire,
    input  pix_t             in_item,
    input  logic             out_ready,
    input  logic [RGB_W-1:0] pal_data,
    output logic             advance,
    output logic             pal_rd_en,
    output logic [IDX_W-1:0] pal_addr,
    output logic             out_valid,
    output logic [RGB_W-1:0] out_rgb,
    output logic             out_eol
);

    logic s1_valid;
    pix_t s1;

    assign advance = !(out_valid && !out_ready);

    // while held, keep re-reading the waiting pixel's entry
    always_comb begin
        if (advance) begin
            pal_addr  = in_item.idx;
            pal_rd_en = in_fire;
        end else begin
            pal_addr  = s1.idx;
            pal_rd_en = s1_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid  <= 1'b0;
            s1        <= '0;
            out_valid <= 1'b0;
            out_rgb   <= '0;
            out_eol   <= 1'b0;
        end else if (advance) begin
            s1_valid  <= in_fire;
            s1        <= in_item;
            out_valid <= s1_valid;
            out_rgb   <= (s1.src == SRC_DIRECT) ? s1.direct : pal_data;
            out_eol   <= s1_valid && s1.eol;
        end
    end

endmodule

// File: rtl/pix_color_select.sv
module pix_color_select
    import pxsel_pkg::*;
#(
    parameter int LINE_LEN  = LINE_PIX,
    parameter bit LANE_SWAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [WORD_W-1:0] in_truecolor,
    input  logic [WORD_W-1:0] in_ctrl,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_addr,
    input  logic [RGB_W-1:0]  pal_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RGB_W-1:0]  out_rgb,
    output logic              out_eol
);

    logic fire;
    logic advance;
    logic line_last;
    src_e src;
    rgb_t direct;
    pix_t item;

    assign in_ready = advance;
    assign fire     = in_valid && advance;

    pxsel_decode #(.LANE_SWAP(LANE_SWAP)) u_decode (
        .truecolor (in_truecolor),
        .ctrl      (in_ctrl),
        .src       (src),
        .direct    (direct)
    );

    pxsel_linepos #(.LINE_LEN(LINE_LEN)) u_linepos (
        .clk  (clk),
        .rst  (rst),
        .step (fire),
        .last (line_last)
    );

    always_comb begin
        item.src    = src;
        item.idx    = in_index;
        item.direct = direct;
        item.eol    = line_last;
    end

    pxsel_pipe u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (fire),
        .in_item   (item),
        .out_ready (out_ready),
        .pal_data  (pal_data),
        .advance   (advance),
        .pal_rd_en (pal_rd_en),
        .pal_addr  (pal_addr),
        .out_valid (out_valid),
        .out_rgb   (out_rgb),
        .out_eol   (out_eol)
    );

endmodule

// File: rtl/pix_color_select_chk.sv
module pix_color_select_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  in_index,
    input logic        pal_rd_en,
    input logic [7:0]  pal_addr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [23:0] out_rgb,
    input logic        out_eol
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_eol));

    p_read_on_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (pal_rd_en && pal_addr == in_index));

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> ##1 out_valid);

    p_ready_low_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_rgb) && $stable(out_eol)));

    p_eol_valid_r8: assert property (@(posedge clk) disable iff (rst)
        out_eol |-> out_valid);

endmodule

bind pix_color_select pix_color_select_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_index  (in_index),
    .pal_rd_en (pal_rd_en),
    .pal_addr  (pal_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_rgb   (out_rgb),
    .out_eol   (out_eol)
);

// File: tb/sim_pix_color_select.sv
module sim_pix_color_select;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_index;
    logic [31:0] in_truecolor;
    logic [31:0] in_ctrl;
    logic        pal_rd_en;
    logic [7:0]  pal_addr;
    logic [23:0] pal_data;
    logic        out_valid;
    logic        out_ready;
    logic [23:0] out_rgb;
    logic        out_eol;

    always #4 clk = ~clk;

    pix_color_select u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_index(in_index),
        .in_truecolor(in_truecolor), .in_ctrl(in_ctrl),
        .pal_rd_en(pal_rd_en), .pal_addr(pal_addr), .pal_data(pal_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_rgb(out_rgb), .out_eol(out_eol)
    );

    function automatic logic [23:0] tab_val(input logic [7:0] i);
        return {i ^ 8'h5a, ~i, i * 8'd3};
    endfunction

    // external synchronous lookup table model
    always @(posedge clk) if (pal_rd_en) pal_data <= tab_val(pal_addr);

    typedef struct {
        logic [23:0] rgb;
        logic        eol;
        int          cyc;
        bit          lat;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   acc_cnt = 0;
    bit   bp_on = 1'b0;
    bit   ended = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic send(input logic [7:0] idx, input logic [31:0] tc, input logic [31:0] ctl);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_index = idx; in_truecolor = tc; in_ctrl = ctl;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        check(pal_rd_en && pal_addr == idx, "R4", {23'd0, pal_rd_en, pal_addr}, {23'd0, 1'b1, idx});
        if (ctl[7:0] == 8'h03) begin
            e.rgb = {tc[15:8], tc[23:16], tc[31:24]};
            e.req = "R2";
        end else begin
            e.rgb = tab_val(idx);
            e.req = bp_on ? "R3/R7" : "R3";
        end
        e.eol = ((acc_cnt % 1024) == 1023);
        e.cyc = cyc;
        e.lat = !bp_on;
        q.push_back(e);
        acc_cnt++;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic send_random(input int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] ctl;
            ctl = $urandom;
            if ($urandom % 3 == 0) ctl[7:0] = 8'h03;
            send(8'($urandom), $urandom, ctl);
        end
    endtask

    task automatic drain();
        int t = 0;
        while (q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    // monitor: drives out_ready, compares against the queue
    bit          held = 1'b0;
    logic [23:0] held_rgb;
    logic        held_eol;
    initial begin
        out_ready = 1'b1;
        forever begin
            @(negedge clk);
            out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
            #1;
            if (!rst && out_valid) begin
                if (held) begin
                    check(out_rgb == held_rgb && out_eol == held_eol, "R6 hold",
                          {7'd0, out_eol, out_rgb}, {7'd0, held_eol, held_rgb});
                end
                if (!out_ready) begin
                    check(!in_ready, "R6 ready", {31'd0, in_ready}, 32'd0);
                    held = 1'b1; held_rgb = out_rgb; held_eol = out_eol;
                end else begin
                    held = 1'b0;
                    if (q.size() == 0) begin
                        check(1'b0, "R9 unexpected output", {8'd0, out_rgb}, 32'd0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(out_rgb == e.rgb, e.req, {8'd0, out_rgb}, {8'd0, e.rgb});
                        check(out_eol == e.eol, "R8", {31'd0, out_eol}, {31'd0, e.eol});
                        if (e.lat)
                            check(cyc - e.cyc == 2, "R5 latency", cyc - e.cyc, 32'd2);
                    end
                end
            end else begin
                held = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", q.size(), 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_index = '0; in_truecolor = '0; in_ctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(!out_valid && !out_eol, "R1 outputs", {30'd0, out_valid, out_eol}, 32'd0);
        check(in_ready, "R1 ready", {31'd0, in_ready}, 32'd1);

        // directed, no backpressure
        send(8'h10, 32'h332211ff, 32'h12345603);   // R2 direct
        send(8'h20, 32'hccbbaa00, 32'h00000003);   // R2 direct, low byte ignored
        send(8'h30, 32'h33221100, 32'h03000000);   // R3: tag in wrong byte
        send(8'h00, 32'h11111111, 32'h00000002);   // R3
        send(8'hff, 32'h22222222, 32'h00000083);   // R3
        send(8'h7e, 32'h44444444, 32'hffffffff);   // R3
        drain();

        // R9: idle cycles, no new output
        repeat (6) @(negedge clk);
        check(q.size() == 0, "R9 idle", q.size(), 32'd0);

        // R6/R7: random backpressure with mixed sources
        bp_on = 1'b1;
        send_random(300);
        drain();
        bp_on = 1'b0;

        // R8: run past two line ends
        send_random(2048 - acc_cnt + 20);
        drain();

        // R7/R8: line end under backpressure
        bp_on = 1'b1;
        send_random(1030);
        drain();
        bp_on = 1'b0;
        repeat (4) @(negedge clk);

        check(q.size() == 0, "R5 order/all delivered", q.size(), 32'd0);
        finish_run();
    end

endmodule